// File: doc/BRIEF.md
# Byte-Writable Compare Match Timer

This block is a single-channel interval timer. A 16-bit up-counter advances by one on every peripheral clock edge where both the software start bit and the external count-enable pulse are high. A 16-bit compare register holds the period. When the counter equals the compare value, the counter returns to zero and a sticky match flag is raised. An interrupt request follows the flag when software has enabled it.

Software reaches the block through a simple register bus with a write port and a read port. The write port has one byte-lane strobe per byte, so each of the three registers can be written as a full 16-bit word or as its high byte or its low byte alone. Bus writes to the counter always win over counting. The comparison runs on every cycle, whether or not counting is enabled.

Top module: `cmp_match_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the compare register reads 0xFFFF, the control/status register reads 0x0000 and `irq` is 0. The register addresses are 0 for control/status, 1 for the counter and 2 for the compare register. In control/status, bit 0 is the start bit, bit 6 is the interrupt enable and bit 7 is the match flag.
- R2: When start is 1, `count_en` is 1, the counter is not being written and it does not equal the compare value, the counter increments by one. An all-ones counter wraps through the match rule in R5.
- R3: A write with `wr_be[1]` set loads data bits 15:8 into register bits 15:8. A write with `wr_be[0]` set loads data bits 7:0 into register bits 7:0. A write with both strobes set loads the full word. This applies to the counter and to the compare register.
- R4: A counter write of either width in a counting cycle discards that cycle's increment. The byte that is not written keeps its value and takes no carry.
- R5: When the counter equals the compare value and is not being written, the counter becomes 0x0000 on the next edge. The clear wins over the increment, and the match flag becomes 1.
- R6: The comparison stays active when counting is stopped. Loading the counter with the compare value while stopped sets the flag and clears the counter one cycle later.
- R7: The match flag is sticky. Writing 1 to bit 7 has no effect. A write of 0 to bit 7 with strobe 0 clears the flag only after software has read control/status (`rd_en` at address 0) while the flag was 1.
- R8: A match in the same cycle as a clearing write leaves the flag at 1.
- R9: `irq` is 1 exactly when the match flag and the interrupt enable are both 1.
- R10: When start or `count_en` is 0 and there is neither a match nor a counter write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_en | input | 1 | Count pulse, qualified by the start bit |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 2 | Write register address |
| wr_be | input | 2 | Byte-lane strobes (bit 1 = high byte) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read request; arms flag clearing |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the counter rules on every cycle: increment while running, hold while idle, clear after a match, the frozen unwritten byte during a byte write, and that the flag only drops after a clearing write. Three behaviours need sequences that only the bench's scenarios can build. The first is the read-then-write handshake for clearing the flag. The second is the match that collides with a clearing write. The third is the exact byte values produced by lane writes that race a count. The bench also covers the interrupt gating by the enable bit and the wrap from all-ones.

// File: rtl/cmp_match_timer.sv
module cmp_match_timer #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 count_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W/8-1:0]   wr_be,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [CNT_W-1:0]     rd_data,
  output logic                 irq
);
  localparam int NB = CNT_W / 8;
  localparam int START_BIT = 0;
  localparam int IE_BIT    = 6;
  localparam int FLAG_BIT  = 7;
  localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(2);

  logic [CNT_W-1:0] cnt_q, cmp_q, cnt_nx, cnt_lane, cmp_lane;
  logic start_q, ie_q, flag_q, armed_q, flag_nx;

  wire hit_cnt  = wr_en && (wr_addr == A_CNT) && (|wr_be);
  wire hit_cmp  = wr_en && (wr_addr == A_CMP) && (|wr_be);
  wire hit_csr  = wr_en && (wr_addr == A_CSR) && wr_be[0];
  wire match    = (cnt_q == cmp_q);
  wire run      = start_q && count_en;
  wire flag_clr = hit_csr && !wr_data[FLAG_BIT] && armed_q;

  genvar i;
  generate
    for (i = 0; i < NB; i++) begin : g_lane
      assign cnt_lane[8*i +: 8] = wr_be[i] ? wr_data[8*i +: 8] : cnt_q[8*i +: 8];
      assign cmp_lane[8*i +: 8] = wr_be[i] ? wr_data[8*i +: 8] : cmp_q[8*i +: 8];
    end
  endgenerate

  always_comb begin
    if (hit_cnt)    cnt_nx = cnt_lane;
    else if (match) cnt_nx = '0;
    else if (run)   cnt_nx = cnt_q + CNT_W'(1);
    else            cnt_nx = cnt_q;
  end

  assign flag_nx = match || (flag_q && !flag_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmp_q   <= '1;
      start_q <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      flag_q <= flag_nx;
      if (hit_cmp) cmp_q <= cmp_lane;
      if (hit_csr) begin
        start_q <= wr_data[START_BIT];
        ie_q    <= wr_data[IE_BIT];
      end
      if (!flag_nx)
        armed_q <= 1'b0;
      else if (rd_en && (rd_addr == A_CSR) && flag_q)
        armed_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CSR: begin
        rd_data[START_BIT] = start_q;
        rd_data[IE_BIT]    = ie_q;
        rd_data[FLAG_BIT]  = flag_q;
      end
      A_CNT:   rd_data = cnt_q;
      A_CMP:   rd_data = cmp_q;
      default: rd_data = '0;
    endcase
  end

  assign irq = flag_q && ie_q;
endmodule

module cmp_match_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               count_en,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [CNT_W/8-1:0] wr_be,
  input logic [CNT_W-1:0]   wr_data,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   cmp,
  input logic               start,
  input logic               flag
);
  wire cnt_w  = wr_en && (wr_addr == ADDR_W'(1)) && (|wr_be);
  wire clr_w  = wr_en && (wr_addr == ADDR_W'(0)) && wr_be[0] && !wr_data[7];
  wire eq     = (cnt == cmp);
  wire going  = start && count_en;

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (going && !cnt_w && !eq) |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_low_byte_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_w && wr_be == 2'b10) |=> (cnt[7:0] == $past(cnt[7:0])));

  assert_high_byte_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_w && wr_be == 2'b01) |=> (cnt[15:8] == $past(cnt[15:8])));

  assert_match_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eq && !cnt_w) |=> (cnt == '0));

  assert_match_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eq |=> flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_w) |=> flag);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!going && !cnt_w && !eq) |=> $stable(cnt));
endmodule

bind cmp_match_timer cmp_match_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_en(count_en), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
  .cnt(cnt_q), .cmp(cmp_q), .start(start_q), .flag(flag_q)
);

// File: tb/cmp_match_timer_tb.sv
module cmp_match_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic count_en = 0, wr_en = 0, rd_en = 0;
  logic [1:0] wr_addr = 0, wr_be = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmp_match_timer u_dut (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // {wr, addr, be, data, cen, exp_cnt, exp_flag}
  localparam int NV = 17;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 2'd0, 2'b01, 16'h0041, 1'b0, 16'h0000, 1'b0}, // R1 start+ie
    {1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 16'h0001, 1'b0}, // R2
    {1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 16'h0002, 1'b0}, // R2
    {1'b1, 2'd2, 2'b11, 16'h0005, 1'b1, 16'h0003, 1'b0}, // R3 compare
    {1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 16'h0004, 1'b0},
    {1'b0, 2'd0, 2'b00, 16'h0000, 1'b0, 16'h0004, 1'b0}, // R10
    {1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 16'h0005, 1'b0},
    {1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 16'h0000, 1'b1}, // R5
    {1'b1, 2'd1, 2'b10, 16'h1234, 1'b1, 16'h1200, 1'b1}, // R4
    {1'b1, 2'd1, 2'b01, 16'h00FF, 1'b1, 16'h12FF, 1'b1}, // R4
    {1'b1, 2'd1, 2'b10, 16'h3400, 1'b1, 16'h34FF, 1'b1}, // R4 no carry
    {1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 16'h3500, 1'b1}, // R2 carry
    {1'b1, 2'd1, 2'b11, 16'h0100, 1'b1, 16'h0100, 1'b1}, // R4 word
    {1'b1, 2'd0, 2'b01, 16'h00C0, 1'b0, 16'h0100, 1'b1}, // R7 write 1
    {1'b1, 2'd1, 2'b11, 16'h0005, 1'b1, 16'h0005, 1'b1}, // R10 stopped
    {1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 16'h0000, 1'b1}, // R6
    {1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 16'h0000, 1'b1}  // R10
  };

  task automatic cyc(input logic w, input logic [1:0] a, input logic [1:0] be,
                     input logic [15:0] d, input logic cen, input logic rd);
    wr_en = w; wr_addr = a; wr_be = be; wr_data = d; count_en = cen;
    rd_en = rd; rd_addr = a;
    @(negedge clk);
    wr_en = 0; count_en = 0; rd_en = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v;
    @(negedge clk); @(negedge clk);
    peek(2'd1, v); chk("R1 cnt reset", v, 16'h0000);
    peek(2'd2, v); chk("R1 cmp reset", v, 16'hFFFF);
    peek(2'd0, v); chk("R1 csr reset", v, 16'h0000);
    chk("R1 irq reset", {15'd0, irq}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [38:0] e;
      e = VEC[k];
      cyc(e[38], e[37:36], e[35:34], e[33:18], e[17], 1'b0);
      peek(2'd1, v); chk($sformatf("R2-R6 vec %0d cnt", k), v, e[16:1]);
      peek(2'd0, v); chk($sformatf("R7 vec %0d flag", k), {15'd0, v[7]}, {15'd0, e[0]});
    end

    // R9: flag=1, ie=1 -> irq
    chk("R9 irq on", {15'd0, irq}, 16'd1);
    // R7: clear without prior read does nothing
    cyc(1'b1, 2'd0, 2'b01, 16'h0040, 1'b0, 1'b0);
    peek(2'd0, v); chk("R7 unarmed clear ignored", {15'd0, v[7]}, 16'd1);
    // R7: read then write 0 clears
    cyc(1'b0, 2'd0, 2'b00, 16'h0000, 1'b0, 1'b1);
    cyc(1'b1, 2'd0, 2'b01, 16'h0040, 1'b0, 1'b0);
    peek(2'd0, v); chk("R7 armed clear", {15'd0, v[7]}, 16'd0);
    chk("R9 irq off after clear", {15'd0, irq}, 16'd0);
    // R8: match collides with clearing write
    cyc(1'b1, 2'd1, 2'b11, 16'h0005, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 2'b00, 16'h0000, 1'b0, 1'b0);
    peek(2'd0, v); chk("R6 flag from loaded match", {15'd0, v[7]}, 16'd1);
    cyc(1'b0, 2'd0, 2'b00, 16'h0000, 1'b0, 1'b1);
    cyc(1'b1, 2'd1, 2'b11, 16'h0005, 1'b0, 1'b0);
    cyc(1'b1, 2'd0, 2'b01, 16'h0040, 1'b0, 1'b0);
    peek(2'd0, v); chk("R8 match beats clear", {15'd0, v[7]}, 16'd1);
    peek(2'd1, v); chk("R8 cnt cleared", v, 16'h0000);
    // R9: ie off hides flag
    cyc(1'b1, 2'd0, 2'b01, 16'h0080, 1'b0, 1'b0);
    chk("R9 irq gated by ie", {15'd0, irq}, 16'd0);
    // R2/R5 wrap from all-ones
    cyc(1'b1, 2'd2, 2'b11, 16'hFFFF, 1'b0, 1'b0);
    cyc(1'b1, 2'd1, 2'b11, 16'hFFFE, 1'b0, 1'b0);
    cyc(1'b1, 2'd0, 2'b01, 16'h0081, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 1'b0);
    peek(2'd1, v); chk("R2 reach FFFF", v, 16'hFFFF);
    cyc(1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 1'b0);
    peek(2'd1, v); chk("R5 wrap to 0", v, 16'h0000);
    // R3: compare high byte lane only
    cyc(1'b1, 2'd2, 2'b10, 16'h12AB, 1'b0, 1'b0);
    peek(2'd2, v); chk("R3 cmp high lane", v, 16'h12FF);
    summary();
  end
endmodule